// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the byte-wide host side of a three-channel interval timer. A host reaches it through a 2-bit address, separate write and read strobes, and 8-bit data buses. Address 3 takes control words; addresses 0 to 2 are the count ports of the channels. The block keeps each channel's access mode, counting mode and BCD flag, and splits 16-bit counts into low and high bytes in both directions. It emits a one-cycle load strobe with a 16-bit value to the counter that is being programmed.

The counters themselves live outside. Each one presents its live count and its output level to this block. Latch commands, whether for one channel or for several at once through a read-back command, freeze a count or a status byte until the host has read it. Count port reads return a pending status first, then a pending count, then the live count.

Top module: `tmr_regif`

## Requirements
- R1: Address 3 is the control port and addresses 0..2 are the count ports of channels 0..2. A read of address 3 returns 0x00 and changes no state. While rd_i is low, rdata_o is 0x00. rdata_o is valid in the same cycle as rd_i, and the side effects of a read take place at the clock edge that ends that cycle.
- R2: In a control write, bits 7:6 select the channel (3 = read-back) and bits 5:4 set the access mode: 1 = low byte only, 2 = high byte only, 3 = low then high. Bits 3:1 give the counting mode, with 6 and 7 stored as 2 and 3, and bit 0 is the BCD flag. mode_o (3 bits per channel, channel c at [3c+2:3c]) and bcd_o change only after a control write.
- R3: In low-byte-only mode, a count port write raises bit c of load_o for exactly the next cycle, with load_val_o[16c+15:16c] = {8'h00, byte}. No other channel's load bit rises.
- R4: In high-byte-only mode, a count port write loads {byte, 8'h00}.
- R5: In low-then-high mode, the first write only holds the byte and issues no load. The second write loads {second, first}. A control write to the channel restarts the sequence at the low byte.
- R6: Live count reads return bits 7:0 in low-only mode and bits 15:8 in high-only mode. In low-then-high mode they alternate low, high, low and so on, and a control write restarts them at low.
- R7: A control write with bits 5:4 = 0 latches the live count of the selected channel. Reads then return the latched value: one byte per the access mode in the single-byte modes, or low then high in low-then-high mode. The last of these reads releases the latch. Latched reads leave the live-read sequence untouched.
- R8: A count latch request is ignored while that channel's latched count is unread, and a status latch request is ignored while its latched status is unread.
- R9: The status byte is {out, 0, access[1:0], mode[2:0], bcd}, captured at the latch edge. A pending status is returned before a pending count, and a single read clears it.
- R10: A read-back command selects channels 0, 1 and 2 with bits 1, 2 and 3. For every selected channel, a clear bit 5 latches the count and a clear bit 4 latches the status. Unselected channels are untouched.
- R11: After reset every channel is in low-byte-only access mode with mode 0 and BCD 0, holds no latches, and has both byte sequencers at the low byte. load_o and load_val_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe, one byte per cycle |
| rd_i | input | 1 | Read strobe, one byte per cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| live_cnt_i | input | NCH*16 | Live count of each channel |
| chan_out_i | input | NCH | Output level of each channel |
| load_o | output | NCH | Per-channel load strobe |
| load_val_o | output | NCH*16 | Per-channel load value |
| mode_o | output | NCH*3 | Per-channel counting mode |
| bcd_o | output | NCH | Per-channel BCD flag |

## Verification
The bench builds the block with its default of three channels, so every channel select, every read-back channel mask and the reserved select value 3 can all be exercised. With 8-bit data, it sweeps every byte value through each access mode on each channel. It also writes every combination of control mode, BCD flag and access mode to every channel and reads each one back as a status byte. Expected load values, status bytes and byte orderings are computed in the bench from the bit fields.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned MODE_W = 3;

  // access field; ACC_NONE doubles as "no count latched"
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_LOHI = 2'd3
  } acc_e;

  function automatic logic [MODE_W-1:0] fold_mode(input logic [MODE_W-1:0] m);
    return (m[2] & m[1]) ? {1'b0, m[1:0]} : m;
  endfunction
endpackage

// File: rtl/tmr_ctrl_dec.sv
module tmr_ctrl_dec
  import tmr_regif_pkg::*;
#(
  parameter int unsigned NCH = 3
) (
  input  logic                    wr_i,
  input  logic [1:0]              addr_i,
  input  logic [BYTE_W-1:0]       wdata_i,
  output logic [NCH-1:0]          cfg_we_o,
  output logic [NCH-1:0]          lat_cnt_o,
  output logic [NCH-1:0]          lat_sts_o,
  output acc_e                    cfg_acc_o,
  output logic [MODE_W-1:0]       cfg_mode_o,
  output logic                    cfg_bcd_o
);
  logic       ctl_wr, rbk;
  logic [1:0] sel;

  assign ctl_wr     = wr_i && (addr_i == 2'd3);
  assign sel        = wdata_i[7:6];
  assign rbk        = (sel == 2'd3);
  assign cfg_acc_o  = acc_e'(wdata_i[5:4]);
  assign cfg_mode_o = fold_mode(wdata_i[3:1]);
  assign cfg_bcd_o  = wdata_i[0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit, pick;
    assign hit  = ctl_wr && !rbk && (sel == 2'(c));
    assign pick = ctl_wr && rbk && wdata_i[1+c];
    assign cfg_we_o[c]  = hit && (cfg_acc_o != ACC_NONE);
    assign lat_cnt_o[c] = (hit && (cfg_acc_o == ACC_NONE)) || (pick && !wdata_i[5]);
    assign lat_sts_o[c] = pick && !wdata_i[4];
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_regif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  acc_e              cfg_acc_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic              cfg_bcd_i,
  input  logic              lat_cnt_i,
  input  logic              lat_sts_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  live_i,
  input  logic              out_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              bcd_o
);
  acc_e              acc_q, cl_st_q;
  logic [MODE_W-1:0] mode_q;
  logic              bcd_q, wr_hi_q, rd_hi_q, sp_q;
  logic [BYTE_W-1:0] lo_hold_q, sts_q;
  logic [CNT_W-1:0]  cl_val_q;

  assign mode_o = mode_q;
  assign bcd_o  = bcd_q;

  // status > latched count > live count
  always_comb begin
    if (sp_q)                    rdata_o = sts_q;
    else if (cl_st_q == ACC_HI)  rdata_o = cl_val_q[CNT_W-1 -: BYTE_W];
    else if (cl_st_q != ACC_NONE) rdata_o = cl_val_q[BYTE_W-1:0];
    else if (acc_q == ACC_HI || (acc_q == ACC_LOHI && rd_hi_q))
                                 rdata_o = live_i[CNT_W-1 -: BYTE_W];
    else                         rdata_o = live_i[BYTE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= ACC_LO;
      mode_q     <= '0;
      bcd_q      <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      lo_hold_q  <= '0;
      cl_st_q    <= ACC_NONE;
      cl_val_q   <= '0;
      sp_q       <= 1'b0;
      sts_q      <= '0;
      load_o     <= 1'b0;
      load_val_o <= '0;
    end else begin
      load_o <= 1'b0;
      if (cfg_we_i) begin
        acc_q   <= cfg_acc_i;
        mode_q  <= cfg_mode_i;
        bcd_q   <= cfg_bcd_i;
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end else begin
        if (wr_i) begin
          unique case (acc_q)
            ACC_HI: begin
              load_o     <= 1'b1;
              load_val_o <= {wdata_i, {BYTE_W{1'b0}}};
            end
            ACC_LOHI: begin
              if (wr_hi_q) begin
                load_o     <= 1'b1;
                load_val_o <= {wdata_i, lo_hold_q};
              end else begin
                lo_hold_q <= wdata_i;
              end
              wr_hi_q <= ~wr_hi_q;
            end
            default: begin
              load_o     <= 1'b1;
              load_val_o <= {{BYTE_W{1'b0}}, wdata_i};
            end
          endcase
        end
        if (rd_i) begin
          if (sp_q)                     sp_q    <= 1'b0;
          else if (cl_st_q == ACC_LOHI) cl_st_q <= ACC_HI;
          else if (cl_st_q != ACC_NONE) cl_st_q <= ACC_NONE;
          else if (acc_q == ACC_LOHI)   rd_hi_q <= ~rd_hi_q;
        end
      end
      if (lat_cnt_i && cl_st_q == ACC_NONE) begin
        cl_val_q <= live_i;
        cl_st_q  <= acc_q;
      end
      if (lat_sts_i && !sp_q) begin
        sp_q  <= 1'b1;
        sts_q <= {out_i, 1'b0, acc_q, mode_q, bcd_q};
      end
    end
  end
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_regif_pkg::*;
#(
  parameter int unsigned NCH = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              addr_i,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [BYTE_W-1:0]       wdata_i,
  output logic [BYTE_W-1:0]       rdata_o,
  input  logic [NCH*CNT_W-1:0]    live_cnt_i,
  input  logic [NCH-1:0]          chan_out_i,
  output logic [NCH-1:0]          load_o,
  output logic [NCH*CNT_W-1:0]    load_val_o,
  output logic [NCH*MODE_W-1:0]   mode_o,
  output logic [NCH-1:0]          bcd_o
);
  logic [NCH-1:0]    cfg_we, lat_cnt, lat_sts;
  acc_e              cfg_acc;
  logic [MODE_W-1:0] cfg_mode;
  logic              cfg_bcd;
  logic [BYTE_W-1:0] ch_rdata [NCH];

  tmr_ctrl_dec #(.NCH(NCH)) dec_i (
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cfg_we_o   (cfg_we),
    .lat_cnt_o  (lat_cnt),
    .lat_sts_o  (lat_sts),
    .cfg_acc_o  (cfg_acc),
    .cfg_mode_o (cfg_mode),
    .cfg_bcd_o  (cfg_bcd)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel = (addr_i == 2'(c));
    tmr_chan_regs ch_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we[c]),
      .cfg_acc_i  (cfg_acc),
      .cfg_mode_i (cfg_mode),
      .cfg_bcd_i  (cfg_bcd),
      .lat_cnt_i  (lat_cnt[c]),
      .lat_sts_i  (lat_sts[c]),
      .wr_i       (wr_i && sel),
      .rd_i       (rd_i && !wr_i && sel),  // write wins a collision
      .wdata_i    (wdata_i),
      .live_i     (live_cnt_i[c*CNT_W +: CNT_W]),
      .out_i      (chan_out_i[c]),
      .rdata_o    (ch_rdata[c]),
      .load_o     (load_o[c]),
      .load_val_o (load_val_o[c*CNT_W +: CNT_W]),
      .mode_o     (mode_o[c*MODE_W +: MODE_W]),
      .bcd_o      (bcd_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++)
      if (rd_i && addr_i == 2'(c)) rdata_o = ch_rdata[c];
  end
endmodule

// File: rtl/tmr_regif_chk.sv
module tmr_regif_chk
  import tmr_regif_pkg::*;
#(
  parameter int unsigned NCH = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [1:0]            addr_i,
  input logic                  wr_i,
  input logic                  rd_i,
  input logic [BYTE_W-1:0]     rdata_o,
  input logic [NCH-1:0]        load_o,
  input logic [NCH*CNT_W-1:0]  load_val_o,
  input logic [NCH*MODE_W-1:0] mode_o,
  input logic [NCH-1:0]        bcd_o
);
  // R1
  ctl_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd3) |-> (rdata_o == '0));

  // R1
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0));

  // R3
  load_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_o));

  // R3
  load_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|load_o) |-> $past(wr_i && addr_i != 2'd3));

  // R3
  load_val_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|load_o) |-> $stable(load_val_o));

  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == 2'd3) |=> ($stable(mode_o) && $stable(bcd_o)));
endmodule

bind tmr_regif tmr_regif_chk #(.NCH(NCH)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .rdata_o    (rdata_o),
  .load_o     (load_o),
  .load_val_o (load_val_o),
  .mode_o     (mode_o),
  .bcd_o      (bcd_o)
);

// File: tb/tmr_regif_tb_top.sv
`timescale 1ns/1ps
module tmr_regif_tb_top;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0, rdata;
  logic [15:0] live [NCH];
  logic [2:0]  chan_out = '0;
  logic [47:0] live_cnt, load_val;
  logic [2:0]  load, bcd;
  logic [8:0]  mode;
  int checks = 0, fails = 0;
  int e_acc [NCH], e_mode [NCH], e_bcd [NCH];

  assign live_cnt = {live[2], live[1], live[0]};

  always #2 clk = ~clk;

  tmr_regif #(.NCH(NCH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .live_cnt_i(live_cnt),
    .chan_out_i(chan_out), .load_o(load), .load_val_o(load_val),
    .mode_o(mode), .bcd_o(bcd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic int fold(input int m);
    return (m > 5) ? m - 4 : m;
  endfunction

  task automatic ctrl(input int ch, input int acc, input int m, input int b);
    do_wr(2'd3, {2'(ch), 2'(acc), 3'(m), 1'(b)});
    e_acc[ch] = acc; e_mode[ch] = fold(m); e_bcd[ch] = b;
  endtask

  // read-back: lc/ls = latch count/status, sel = channel mask
  task automatic rbk(input bit lc, input bit ls, input logic [2:0] sel);
    do_wr(2'd3, {2'b11, ~lc, ~ls, sel, 1'b0});
  endtask

  task automatic chk_cfg(input string tag);
    for (int c = 0; c < NCH; c++) begin
      chk({tag, " mode"}, 32'(mode[c*3 +: 3]), 32'(e_mode[c]));
      chk({tag, " bcd"}, 32'(bcd[c]), 32'(e_bcd[c]));
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [15:0] old;
    for (int c = 0; c < NCH; c++) begin
      live[c] = 16'h0; e_acc[c] = 1; e_mode[c] = 0; e_bcd[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 load", 32'(load), 32'h0);
    chk("R11 load_val", 32'(load_val[31:0]), 32'h0);
    chk_cfg("R11");
    chk("R1 idle rdata", 32'(rdata), 32'h0);
    live[0] = 16'hA55A;
    do_rd(2'd0, v); chk("R11 low-only read", 32'(v), 32'h5A);
    do_rd(2'd0, v); chk("R11 low-only again", 32'(v), 32'h5A);
    rbk(1'b0, 1'b1, 3'b001);
    do_rd(2'd0, v); chk("R11 status", 32'(v), 32'h10);

    // R2 R9 R10 control decode sweep with status readback
    for (int ch = 0; ch < NCH; ch++)
      for (int a = 1; a < 4; a++)
        for (int m = 0; m < 8; m++)
          for (int b = 0; b < 2; b++) begin
            ctrl(ch, a, m, b);
            chk_cfg("R2 cfg");
            chan_out[ch] = 1'((m + b + ch) & 1);
            rbk(1'b0, 1'b1, 3'(1 << ch));
            do_rd(2'(ch), v);
            chk("R9 status", 32'(v),
                32'({chan_out[ch], 1'b0, 2'(a), 3'(fold(m)), 1'(b)}));
          end

    // R3 R4 R5 load sweeps
    for (int ch = 0; ch < NCH; ch++) begin
      ctrl(ch, 1, 0, 0);
      for (int d = 0; d < 256; d++) begin
        do_wr(2'(ch), 8'(d));
        chk("R3 load", 32'(load), 32'(1 << ch));
        chk("R3 value", 32'(load_val[ch*16 +: 16]), 32'(d));
      end
      ctrl(ch, 2, 0, 0);
      for (int d = 0; d < 256; d++) begin
        do_wr(2'(ch), 8'(d));
        chk("R4 load", 32'(load), 32'(1 << ch));
        chk("R4 value", 32'(load_val[ch*16 +: 16]), 32'(d * 256));
      end
      ctrl(ch, 3, 0, 0);
      for (int d = 0; d < 256; d++) begin
        do_wr(2'(ch), 8'(d));
        chk("R5 first no load", 32'(load), 32'h0);
        do_wr(2'(ch), 8'(255 - d));
        chk("R5 load", 32'(load), 32'(1 << ch));
        chk("R5 value", 32'(load_val[ch*16 +: 16]), 32'((255 - d) * 256 + d));
      end
      do_wr(2'(ch), 8'h11);
      ctrl(ch, 3, 0, 0);
      do_wr(2'(ch), 8'h22);
      chk("R5 restart no load", 32'(load), 32'h0);
      do_wr(2'(ch), 8'h33);
      chk("R5 restart value", 32'(load_val[ch*16 +: 16]), 32'h3322);
    end

    // R6 live read ordering
    for (int ch = 0; ch < NCH; ch++) begin
      live[ch] = 16'h1234 + 16'(ch * 16'h1111);
      ctrl(ch, 1, 0, 0);
      do_rd(2'(ch), v); chk("R6 lo", 32'(v), 32'(live[ch][7:0]));
      do_rd(2'(ch), v); chk("R6 lo again", 32'(v), 32'(live[ch][7:0]));
      ctrl(ch, 2, 0, 0);
      do_rd(2'(ch), v); chk("R6 hi", 32'(v), 32'(live[ch][15:8]));
      do_rd(2'(ch), v); chk("R6 hi again", 32'(v), 32'(live[ch][15:8]));
      ctrl(ch, 3, 0, 0);
      do_rd(2'(ch), v); chk("R6 seq lo", 32'(v), 32'(live[ch][7:0]));
      do_rd(2'(ch), v); chk("R6 seq hi", 32'(v), 32'(live[ch][15:8]));
      do_rd(2'(ch), v); chk("R6 seq lo2", 32'(v), 32'(live[ch][7:0]));
      ctrl(ch, 3, 0, 0);
      do_rd(2'(ch), v); chk("R6 restart lo", 32'(v), 32'(live[ch][7:0]));
    end

    // R1 address 3 read has no effect on the sequence
    ctrl(0, 3, 0, 0);
    live[0] = 16'hC3D4;
    do_rd(2'd0, v); chk("R1 lo", 32'(v), 32'hD4);
    do_rd(2'd3, v); chk("R1 ctl read", 32'(v), 32'h0);
    do_rd(2'd0, v); chk("R1 hi undisturbed", 32'(v), 32'hC3);

    // R7 R8 count latch per access mode
    for (int ch = 0; ch < NCH; ch++)
      for (int a = 1; a < 4; a++) begin
        ctrl(ch, a, 0, 0);
        live[ch] = 16'hBEEF ^ 16'(ch * 16'h0101);
        old = live[ch];
        do_wr(2'd3, {2'(ch), 6'b0});
        live[ch] = ~old;
        do_wr(2'd3, {2'(ch), 6'b0});  // ignored while pending
        if (a == 1) begin
          do_rd(2'(ch), v); chk("R7 lo latched", 32'(v), 32'(old[7:0]));
          do_rd(2'(ch), v); chk("R8 lo released", 32'(v), 32'(live[ch][7:0]));
        end else if (a == 2) begin
          do_rd(2'(ch), v); chk("R7 hi latched", 32'(v), 32'(old[15:8]));
          do_rd(2'(ch), v); chk("R8 hi released", 32'(v), 32'(live[ch][15:8]));
        end else begin
          do_rd(2'(ch), v); chk("R7 word lo", 32'(v), 32'(old[7:0]));
          do_rd(2'(ch), v); chk("R7 word hi", 32'(v), 32'(old[15:8]));
          do_rd(2'(ch), v); chk("R7 live seq at lo", 32'(v), 32'(live[ch][7:0]));
        end
      end

    // R9 R8 status before count, repeated status latch ignored
    ctrl(1, 3, 5, 1);
    live[1] = 16'h5AA5;
    chan_out[1] = 1'b1;
    rbk(1'b1, 1'b1, 3'b010);
    chan_out[1] = 1'b0;
    live[1] = 16'h0000;
    rbk(1'b0, 1'b1, 3'b010);
    do_rd(2'd1, v); chk("R9 status first", 32'(v), 32'hBB);
    do_rd(2'd1, v); chk("R9 count lo next", 32'(v), 32'hA5);
    do_rd(2'd1, v); chk("R9 count hi next", 32'(v), 32'h5A);
    do_rd(2'd1, v); chk("R8 live after", 32'(v), 32'h00);

    // R10 multi-channel read-back
    for (int c = 0; c < NCH; c++) begin
      ctrl(c, 1, 0, 0);
      live[c] = 16'(16'h0A0 + c);
    end
    rbk(1'b1, 1'b0, 3'b111);
    for (int c = 0; c < NCH; c++) live[c] = 16'(16'h070 + c);
    for (int c = 0; c < NCH; c++) begin
      do_rd(2'(c), v); chk("R10 all latched", 32'(v), 32'(8'hA0 + c));
    end
    rbk(1'b0, 1'b0, 3'b111);
    for (int c = 0; c < NCH; c++) live[c] = 16'(16'h050 + c);
    for (int c = 0; c < NCH; c++) begin
      do_rd(2'(c), v); chk("R10 none latched", 32'(v), 32'(8'h50 + c));
    end
    rbk(1'b1, 1'b0, 3'b001);
    for (int c = 0; c < NCH; c++) live[c] = 16'(16'h030 + c);
    do_rd(2'd2, v); chk("R10 unselected live", 32'(v), 32'h32);
    do_rd(2'd0, v); chk("R10 selected latched", 32'(v), 32'h50);

    finish_run();
  end
endmodule